// File: doc/BRIEF.md
# Vertical-Link Fault Swap Remapper

This block sits between a memory controller and the vertical links of one stacked-DRAM channel. Each physical lane carries either an address bit or a data bit. A lane that has been declared broken is not given a dedicated redundant wire. Instead, it borrows one of a small set of data lanes that were chosen at design time as standby lanes. The borrowing lane stops carrying its own data bit. That bit is written to a replica held in ECC space and is read back from that replica.

Configuration works by marking lanes one at a time. The k-th accepted mark takes standby slot k, and slot k always uses physical lane `LANES-1-k`. The marks collect in a shadow table. The shadow table is copied into the active table only between requests, so a burst never sees a change in mapping part-way through. The steering is purely combinational, both for outbound address and data lanes and for inbound data lanes.

A two-state controller tracks request boundaries. In `S_IDLE`, a beat with `req_valid` and without `req_last` takes the transition `BEAT_OPEN` into `S_BURST`. In `S_BURST`, a beat with `req_valid` and `req_last` takes `BEAT_CLOSE` back to `S_IDLE`. A cycle spent in `S_IDLE` with no request is a `COMMIT` cycle: the shadow table is copied into the active table at the end of that cycle.

Top module: `tsv_swap_remap`

## Requirements
- R1: After reset, no slot is active and `swap_ovf` is 0.
- R2: With no active slot, `phy_tx` equals `{req_wdata, req_addr}` and `req_rdata` equals `phy_rx`. In this state `rep_rd` has no effect and `rep_we` is 0.
- R3: When slot k is active for lane f, physical lane `LANES-1-k` carries the logical bit of lane f, where the logical vector is `{req_wdata, req_addr}` with the address in the low `ADDR_W` bits. This holds for address lanes as well as data lanes, so every address round-trips through a channel in which lane f is stuck.
- R4: On reads, a marked data lane j returns the bit received on the standby lane of its slot. A standby data bit `DATA_W-1-k` whose slot is active returns `rep_rd[k]`. All other bits come from `phy_rx`.
- R5: `rep_we[k]` is 1 exactly when slot k is active and `req_valid` and `req_wr` are both 1. `rep_wd[k]` equals `req_wdata[DATA_W-1-k]` whenever slot k is active.
- R6: A mark that is accepted while all `NSPARE` slots are full sets `swap_ovf`. The flag stays set until reset, and the mapping does not change.
- R7: A mark is ignored and does not consume a slot in three cases: the lane is already marked, the lane is a standby lane (index at or above `LANES-NSPARE`), or the index is at or above `LANES`.
- R8: A mark made in `S_BURST` does not change the mapping of any later beat of that burst. It takes effect only after a `COMMIT` cycle (`S_IDLE` with `req_valid` low).
- R9: The outputs `phy_tx`, `req_rdata`, `rep_we` and `rep_wd` respond to their inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mark | input | 1 | Marks lane `cfg_lane` as faulty |
| cfg_lane | input | LW | Physical lane index to mark |
| swap_ovf | output | 1 | Sticky flag: more marks than standby slots |
| req_valid | input | 1 | Request beat valid |
| req_last | input | 1 | Last beat of a request |
| req_wr | input | 1 | Beat is a write |
| req_addr | input | ADDR_W | Logical address |
| req_wdata | input | DATA_W | Logical write data |
| req_rdata | output | DATA_W | Logical read data |
| phy_tx | output | LANES | Outbound physical lanes (address low, data high) |
| phy_rx | input | DATA_W | Inbound physical data lanes |
| rep_we | output | NSPARE | Write strobe for each replica bit |
| rep_wd | output | NSPARE | Replica bits to store in ECC space |
| rep_rd | input | NSPARE | Replica bits read back from ECC space |

## Verification
The hardest case to reach is a mark that arrives while a burst is still open. The bench drives a multi-beat write and marks a data lane on one of its middle beats. It then checks that the standby lane still carries its own data bit on every remaining beat, and that the swap appears only after one idle cycle. Round-trip sweeps use a far-end model that pins the marked lanes to a constant. These sweeps cover every single non-standby lane, a rotating set of lane pairs, and the overflow and ignored-mark sequences. In each sweep, all addresses are written before any is read, so an address lane that was not swapped would show up as aliasing.

// File: rtl/tsv_swap_pkg.sv
package tsv_swap_pkg;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_BURST = 1'b1
    } req_state_e;

endpackage

// File: rtl/tsv_req_fsm.sv
module tsv_req_fsm
    import tsv_swap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_last,
    output req_state_e state_q,
    output logic       commit
);

    req_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid && !req_last) begin
                    state_d = S_BURST;      // BEAT_OPEN
                end else if (!req_valid) begin
                    commit  = 1'b1;         // COMMIT
                end
            end
            S_BURST: begin
                if (req_valid && req_last) begin
                    state_d = S_IDLE;       // BEAT_CLOSE
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // R8: the table may only be copied between requests
    commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (state_q == S_IDLE) && !req_valid);

endmodule

// File: rtl/tsv_fault_table.sv
module tsv_fault_table #(
    parameter int LANES  = 24,
    parameter int NSPARE = 2,
    parameter int LW     = $clog2(LANES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_mark,
    input  logic [LW-1:0]                 cfg_lane,
    input  logic                          commit,
    output logic [NSPARE-1:0]             act_vld,
    output logic [NSPARE-1:0][LW-1:0]     act_lane,
    output logic                          swap_ovf
);

    localparam int FIRST_STBY = LANES - NSPARE;

    logic [NSPARE-1:0]         shd_vld;
    logic [NSPARE-1:0][LW-1:0] shd_lane;
    logic [NSPARE-1:0]         fill_oh;
    logic                      dup, in_rng, is_stby, accept, full;

    always_comb begin
        logic prior;
        dup   = 1'b0;
        prior = 1'b1;
        for (int k = 0; k < NSPARE; k++) begin
            if (shd_vld[k] && shd_lane[k] == cfg_lane) dup = 1'b1;
            fill_oh[k] = prior && !shd_vld[k];
            prior      = prior && shd_vld[k];
        end
        in_rng  = int'(cfg_lane) < LANES;
        is_stby = int'(cfg_lane) >= FIRST_STBY;
        full    = &shd_vld;
        accept  = cfg_mark && in_rng && !is_stby && !dup;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_vld  <= '0;
            shd_lane <= '0;
            act_vld  <= '0;
            act_lane <= '0;
            swap_ovf <= 1'b0;
        end else begin
            if (accept && full) begin
                swap_ovf <= 1'b1;
            end
            for (int k = 0; k < NSPARE; k++) begin
                if (accept && !full && fill_oh[k]) begin
                    shd_vld[k]  <= 1'b1;
                    shd_lane[k] <= cfg_lane;
                end
            end
            if (commit) begin
                act_vld  <= shd_vld;
                act_lane <= shd_lane;
            end
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ovf |-> &shd_vld);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ovf |=> swap_ovf);

    // R7
    generate
        for (genvar a = 0; a < NSPARE; a++) begin : g_slot
            // R7
            stby_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
                shd_vld[a] |-> int'(shd_lane[a]) < FIRST_STBY);
            for (genvar b = a + 1; b < NSPARE; b++) begin : g_pair
                // R7
                distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (shd_vld[a] && shd_vld[b]) |-> shd_lane[a] != shd_lane[b]);
            end
        end
    endgenerate

endmodule

// File: rtl/tsv_tx_steer.sv
module tsv_tx_steer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NSPARE = 2,
    parameter int LANES  = ADDR_W + DATA_W,
    parameter int LW     = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic                          req_valid,
    input  logic                          req_wr,
    input  logic [NSPARE-1:0]             act_vld,
    input  logic [NSPARE-1:0][LW-1:0]     act_lane,
    output logic [LANES-1:0]              phy_tx,
    output logic [NSPARE-1:0]             rep_we,
    output logic [NSPARE-1:0]             rep_wd
);

    logic [LANES-1:0] logical;

    assign logical = {req_wdata, req_addr};

    always_comb begin
        phy_tx = logical;
        for (int k = 0; k < NSPARE; k++) begin
            rep_we[k] = req_valid && req_wr && act_vld[k];
            rep_wd[k] = act_vld[k] ? req_wdata[DATA_W-1-k] : 1'b0;
            if (act_vld[k]) begin
                phy_tx[LANES-1-k] = logical[act_lane[k]];
            end
        end
    end

endmodule

// File: rtl/tsv_rx_steer.sv
module tsv_rx_steer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NSPARE = 2,
    parameter int LANES  = ADDR_W + DATA_W,
    parameter int LW     = $clog2(LANES)
) (
    input  logic [DATA_W-1:0]             phy_rx,
    input  logic [NSPARE-1:0]             rep_rd,
    input  logic [NSPARE-1:0]             act_vld,
    input  logic [NSPARE-1:0][LW-1:0]     act_lane,
    output logic [DATA_W-1:0]             req_rdata
);

    localparam int DIW = $clog2(DATA_W);

    always_comb begin
        logic [LW-1:0] rel;
        req_rdata = phy_rx;
        // standby bits now live in the replica
        for (int k = 0; k < NSPARE; k++) begin
            if (act_vld[k]) req_rdata[DATA_W-1-k] = rep_rd[k];
        end
        // marked data lanes arrive on their standby lane
        for (int k = 0; k < NSPARE; k++) begin
            rel = act_lane[k] - LW'(ADDR_W);
            if (act_vld[k] && int'(act_lane[k]) >= ADDR_W) begin
                req_rdata[rel[DIW-1:0]] = phy_rx[DATA_W-1-k];
            end
        end
    end

endmodule

// File: rtl/tsv_swap_remap.sv
module tsv_swap_remap
    import tsv_swap_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int NSPARE = 2,
    parameter int LANES  = ADDR_W + DATA_W,
    parameter int LW     = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mark,
    input  logic [LW-1:0]     cfg_lane,
    output logic              swap_ovf,
    input  logic              req_valid,
    input  logic              req_last,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] req_rdata,
    output logic [LANES-1:0]  phy_tx,
    input  logic [DATA_W-1:0] phy_rx,
    output logic [NSPARE-1:0] rep_we,
    output logic [NSPARE-1:0] rep_wd,
    input  logic [NSPARE-1:0] rep_rd
);

    req_state_e                state_q;
    logic                      commit;
    logic [NSPARE-1:0]         act_vld;
    logic [NSPARE-1:0][LW-1:0] act_lane;

    tsv_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_last  (req_last),
        .state_q   (state_q),
        .commit    (commit)
    );

    tsv_fault_table #(.LANES(LANES), .NSPARE(NSPARE), .LW(LW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mark (cfg_mark),
        .cfg_lane (cfg_lane),
        .commit   (commit),
        .act_vld  (act_vld),
        .act_lane (act_lane),
        .swap_ovf (swap_ovf)
    );

    tsv_tx_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSPARE(NSPARE),
                   .LANES(LANES), .LW(LW)) u_tx (
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_valid (req_valid),
        .req_wr    (req_wr),
        .act_vld   (act_vld),
        .act_lane  (act_lane),
        .phy_tx    (phy_tx),
        .rep_we    (rep_we),
        .rep_wd    (rep_wd)
    );

    tsv_rx_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSPARE(NSPARE),
                   .LANES(LANES), .LW(LW)) u_rx (
        .phy_rx    (phy_rx),
        .rep_rd    (rep_rd),
        .act_vld   (act_vld),
        .act_lane  (act_lane),
        .req_rdata (req_rdata)
    );

    // R8
    burst_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BURST) |=> $stable(act_vld) && $stable(act_lane));

    // R2
    identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vld == '0) |-> (phy_tx == {req_wdata, req_addr}) &&
                            (req_rdata == phy_rx) && (rep_we == '0));

    // R5
    rep_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rep_we) |-> req_valid && req_wr);

endmodule

// File: tb/tsv_swap_remap_bench.sv
`timescale 1ns/1ps
module tsv_swap_remap_bench;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NS = 2;
    localparam int LN = AW + DW;
    localparam int LW = $clog2(LN);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_mark;
    logic [LW-1:0] cfg_lane;
    logic          swap_ovf;
    logic          req_valid, req_last, req_wr;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata, req_rdata;
    logic [LN-1:0] phy_tx;
    logic [DW-1:0] phy_rx;
    logic [NS-1:0] rep_we, rep_wd, rep_rd;

    int errs = 0;
    int nchk = 0;
    int flt[NS];
    int nflt = 0;
    bit sval = 1'b0;
    logic [DW-1:0] mem  [256];
    logic [NS-1:0] rmem [256];

    always #2.5 clk = ~clk;

    tsv_swap_remap u_tsv_swap_remap (
        .clk(clk), .rst_n(rst_n), .cfg_mark(cfg_mark), .cfg_lane(cfg_lane),
        .swap_ovf(swap_ovf), .req_valid(req_valid), .req_last(req_last),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_rdata(req_rdata), .phy_tx(phy_tx), .phy_rx(phy_rx),
        .rep_we(rep_we), .rep_wd(rep_wd), .rep_rd(rep_rd)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'((a * 40503 + s * 7919) ^ (a << 8) ^ (s << 3));
    endfunction

    function automatic logic [LN-1:0] pin(input logic [LN-1:0] v);
        for (int i = 0; i < nflt; i++) v[flt[i]] = sval;
        return v;
    endfunction

    // far end: undo the swap on what arrives over the stuck channel
    function automatic logic [LN-1:0] far_decode(input logic [LN-1:0] tx);
        logic [LN-1:0] r, rec;
        r   = pin(tx);
        rec = r;
        for (int k = 0; k < nflt; k++) rec[flt[k]] = r[LN-1-k];
        for (int k = 0; k < nflt; k++) rec[LN-1-k] = 1'b0;
        return rec;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; cfg_mark = 1'b0; cfg_lane = '0;
        req_valid = 1'b0; req_last = 1'b0; req_wr = 1'b0;
        req_addr = '0; req_wdata = '0; phy_rx = '0; rep_rd = '0;
        nflt = 0;
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0; rmem[i] = '1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic mark(input int lane);
        cfg_mark = 1'b1;
        cfg_lane = LW'(lane);
        @(negedge clk);
        cfg_mark = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        logic [LN-1:0] rec, lg;
        req_valid = 1'b1; req_wr = 1'b1; req_last = 1'b1;
        req_addr = AW'(a); req_wdata = d;
        #1;
        lg = {d, AW'(a)};
        if (nflt == 0) begin
            check(phy_tx == lg, "R2 tx identity", 64'(phy_tx), 64'(lg));
            check(rep_we == '0, "R2 no replica write", 64'(rep_we), 64'(0));
        end
        for (int k = 0; k < nflt; k++) begin
            check(phy_tx[LN-1-k] == lg[flt[k]], "R3 standby carries bit",
                  64'(phy_tx[LN-1-k]), 64'(lg[flt[k]]));
            check(rep_we[k] && rep_wd[k] == d[DW-1-k], "R5 replica write",
                  64'({rep_we[k], rep_wd[k]}), 64'({1'b1, d[DW-1-k]}));
        end
        rec = far_decode(phy_tx);
        mem[rec[AW-1:0]] = rec[LN-1:AW];
        for (int k = 0; k < NS; k++) if (rep_we[k]) rmem[a][k] = rep_wd[k];
        @(negedge clk);
    endtask

    task automatic rd(input int a, input logic [DW-1:0] exp, input string req);
        logic [LN-1:0] rec, v;
        req_valid = 1'b1; req_wr = 1'b0; req_last = 1'b1;
        req_addr = AW'(a);
        #1;
        check(rep_we == '0, "R5 no replica write on read", 64'(rep_we), 64'(0));
        rec = far_decode(phy_tx);
        v = {mem[rec[AW-1:0]], AW'(0)};
        for (int k = 0; k < nflt; k++) if (flt[k] >= AW) v[LN-1-k] = v[flt[k]];
        v = pin(v);
        phy_rx = v[LN-1:AW];
        rep_rd = rmem[a];
        #1;
        check(req_rdata == exp, req, 64'(req_rdata), 64'(exp));
        @(negedge clk);
    endtask

    task automatic round_trip(input int seed, input string req);
        for (int a = 0; a < 256; a++) wr(a, pat(a, seed));
        for (int a = 0; a < 256; a++) rd(a, pat(a, seed), req);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 190000);
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check(swap_ovf == 1'b0, "R1 overflow clear", 64'(swap_ovf), 64'(0));
        req_addr = 8'hA5; req_wdata = 16'h3C96; #1;
        check(phy_tx == {16'h3C96, 8'hA5}, "R1 no slot active",
              64'(phy_tx), 64'({16'h3C96, 8'hA5}));
        @(negedge clk);

        // R2 identity with garbage on the replica input; R9 same-cycle
        round_trip(1, "R2 identity round trip");

        // R3 / R4: every non-standby lane alone
        for (int lane = 0; lane < LN - NS; lane++) begin
            do_reset();
            mark(lane);
            flt[0] = lane; nflt = 1; sval = lane[0];
            round_trip(lane + 2, lane < AW ? "R3 address lane swap" : "R4 data lane swap");
        end

        // R3 / R4: rotating pairs of lanes
        for (int lane = 0; lane < LN - NS; lane++) begin
            do_reset();
            flt[0] = lane; flt[1] = (lane + 5) % (LN - NS);
            mark(flt[0]); mark(flt[1]);
            nflt = 2; sval = ~lane[1];
            round_trip(lane + 40, "R4 pair swap");
        end

        // R7: duplicate, standby and out-of-range marks are ignored
        do_reset();
        mark(3); mark(3); mark(LN - 1); mark(30); mark(10);
        check(swap_ovf == 1'b0, "R7 ignored marks take no slot", 64'(swap_ovf), 64'(0));
        flt[0] = 3; flt[1] = 10; nflt = 2; sval = 1'b1;
        round_trip(77, "R7 mapping after ignored marks");

        // R6: third mark overflows and leaves mapping unchanged
        do_reset();
        mark(2); mark(12);
        check(swap_ovf == 1'b0, "R6 full but no overflow", 64'(swap_ovf), 64'(0));
        mark(5);
        check(swap_ovf == 1'b1, "R6 overflow flag", 64'(swap_ovf), 64'(1));
        flt[0] = 2; flt[1] = 12; nflt = 2; sval = 1'b0;
        round_trip(91, "R6 mapping unchanged after overflow");
        check(swap_ovf == 1'b1, "R6 overflow sticky", 64'(swap_ovf), 64'(1));

        // R8: mark during an open burst
        do_reset();
        req_valid = 1'b1; req_wr = 1'b1; req_last = 1'b0;
        req_addr = 8'h00; req_wdata = 16'h0001;
        @(negedge clk);                       // now in burst
        cfg_mark = 1'b1; cfg_lane = LW'(AW);  // data bit 0
        #1;
        check(phy_tx[LN-1] == 1'b0, "R8 burst beat 2 unswapped",
              64'(phy_tx[LN-1]), 64'(0));
        @(negedge clk);
        cfg_mark = 1'b0; req_last = 1'b1;
        #1;
        check(phy_tx[LN-1] == 1'b0, "R8 last beat unswapped",
              64'(phy_tx[LN-1]), 64'(0));
        check(rep_we == '0, "R8 no replica write mid burst", 64'(rep_we), 64'(0));
        @(negedge clk);                       // idle, commit at next edge
        req_valid = 1'b0;
        #1;
        check(phy_tx[LN-1] == 1'b0, "R8 before commit", 64'(phy_tx[LN-1]), 64'(0));
        @(negedge clk);
        req_valid = 1'b1; req_last = 1'b1; req_wdata = 16'h0001;
        #1;
        check(phy_tx[LN-1] == 1'b1, "R8 swap after commit", 64'(phy_tx[LN-1]), 64'(1));
        check(rep_we[0] == 1'b1, "R5 replica write after commit", 64'(rep_we), 64'(1));
        @(negedge clk);
        req_valid = 1'b0;

        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

endmodule